// File: doc/BRIEF.md
# Dual Word and Character Parity Network

This block keeps an 18-bit data register and three control flip-flops, and loaded from a 21-line receive word. Two parity generators work on the stored state. The word generator covers all 18 data bits and the first two control flip-flops. The character generator covers the low six data bits and the first control flip-flop, which serves as the seventh level of an 8-level teletype character. The third control flip-flop holds the received parity bit.

Because both generators read the registers directly, each parity is valid in the same cycle that a new word reaches the register. Two check flags compare the generated parities with the stored parity bit. A mode input chooses the 21-bit outbound format. Word mode attaches the word parity to the top line. Character mode sends a character with its character parity on that same top line.

Top module: `dual_parity_net`

## Requirements
- R1: A synchronous reset (`rst` high at a rising clock edge) clears `data_o` and `ctl_o` to zero. It takes priority over a load.
- R2: When `load_i` is high at a rising edge, `data_o` takes `rx_word_i[17:0]` and `ctl_o[2:0]` takes `rx_word_i[20:18]`. Line k (1-based) is bit k-1, so lines 19, 20 and 21 land in control bits 1, 2 and 3 (`ctl_o[0]`, `ctl_o[1]`, `ctl_o[2]`).
- R3: While `load_i` is low, `data_o` and `ctl_o` keep their values whatever `rx_word_i` carries.
- R4: `word_par_o` makes the number of ones among `data_o`, `ctl_o[1:0]` and itself odd when `ODD_PAR`=1 (the default), and even when `ODD_PAR`=0.
- R5: `char_par_o` makes the number of ones among `data_o[5:0]`, `ctl_o[0]` and itself odd (`ODD_PAR`=1) or even (`ODD_PAR`=0).
- R6: `word_err_o` is high exactly when `word_par_o` differs from the stored parity bit `ctl_o[2]` (receive line 21).
- R7: `char_err_o` is high exactly when `char_par_o` differs from `ctl_o[2]`.
- R8: Both parity outputs and both flags reflect a newly loaded word in the cycle that follows the loading edge, with no added latency.
- R9: With `tx_char_i`=0 (word mode), `tx_word_o[17:0]` = `data_o`, `tx_word_o[19:18]` = `ctl_o[1:0]` and `tx_word_o[20]` = `word_par_o`.
- R10: With `tx_char_i`=1 (character mode), `tx_word_o[5:0]` = `data_o[5:0]`, `tx_word_o[6]` = `ctl_o[0]`, `tx_word_o[19:7]` = 0 and `tx_word_o[20]` = `char_par_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| load_i | input | 1 | Capture strobe for the receive word |
| rx_word_i | input | 21 | Receive lines 1..21 (bit 0 = line 1) |
| tx_char_i | input | 1 | Outbound format: 0 word, 1 character |
| data_o | output | 18 | Data register |
| ctl_o | output | 3 | Control bits 1..3 (bit 2 = parity bit) |
| word_par_o | output | 1 | Generated word parity |
| char_par_o | output | 1 | Generated character parity |
| word_err_o | output | 1 | Word parity disagrees with stored parity bit |
| char_err_o | output | 1 | Character parity disagrees with stored parity bit |
| tx_word_o | output | 21 | Outbound word in the selected format |

## Verification
The assertions assume that `load_i` and `tx_char_i` are known at every rising edge. The format properties also assume that the mode input stays fixed while an outbound word is observed. The bench changes its inputs only on falling edges and holds the mode from one load until the result of that load has been compared. The bench drives a second instance with `ODD_PAR`=0 from the same stimulus, so both parity senses see the same words. The patterns cover all-zero and all-one words, a single set bit in each control line, and words whose stored parity bit is right or wrong for each generator.

// File: rtl/dual_parity_pkg.sv
package dual_parity_pkg;

  typedef enum logic {
    FMT_WORD = 1'b0,
    FMT_CHAR = 1'b1
  } tx_fmt_e;

  // Turn an XOR fold into the bit that completes the requested parity sense.
  function automatic logic complete_parity(input logic fold, input logic odd_sense);
    return odd_sense ? ~fold : fold;
  endfunction

endpackage

// File: rtl/parity_tree.sv
module parity_tree #(
  parameter int WIDTH = 8,
  parameter bit ODD   = 1'b1
) (
  input  logic [WIDTH-1:0] bits_i,
  output logic             par_o
);
  logic [WIDTH-1:0] chain;

  assign chain[0] = bits_i[0];
  for (genvar g = 1; g < WIDTH; g++) begin : g_fold
    assign chain[g] = chain[g-1] ^ bits_i[g];
  end

  assign par_o = dual_parity_pkg::complete_parity(chain[WIDTH-1], ODD);
endmodule

// File: rtl/rx_capture.sv
module rx_capture #(
  parameter int DATA_W = 18,
  parameter int CTL_W  = 3,
  localparam int LINE_W = DATA_W + CTL_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_i,
  input  logic [LINE_W-1:0] rx_i,
  output logic [DATA_W-1:0] data_q,
  output logic [CTL_W-1:0]  ctl_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      data_q <= '0;
      ctl_q  <= '0;
    end else if (load_i) begin
      data_q <= rx_i[DATA_W-1:0];
      ctl_q  <= rx_i[LINE_W-1:DATA_W];
    end
  end
endmodule

// File: rtl/tx_formatter.sv
module tx_formatter #(
  parameter int DATA_W = 18,
  parameter int CHAR_W = 6,
  localparam int LINE_W = DATA_W + 3
) (
  input  dual_parity_pkg::tx_fmt_e fmt_i,
  input  logic [DATA_W-1:0]        data_i,
  input  logic [2:0]               ctl_i,
  input  logic                     word_par_i,
  input  logic                     char_par_i,
  output logic [LINE_W-1:0]        tx_o
);
  always_comb begin
    tx_o = '0;
    if (fmt_i == dual_parity_pkg::FMT_CHAR) begin
      tx_o[CHAR_W-1:0] = data_i[CHAR_W-1:0];
      tx_o[CHAR_W]     = ctl_i[0];
      tx_o[LINE_W-1]   = char_par_i;
    end else begin
      tx_o = {word_par_i, ctl_i[1:0], data_i};
    end
  end
endmodule

// File: rtl/dual_parity_net.sv
module dual_parity_net #(
  parameter int DATA_W  = 18,
  parameter int CHAR_W  = 6,
  parameter bit ODD_PAR = 1'b1,
  localparam int LINE_W = DATA_W + 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_i,
  input  logic [LINE_W-1:0] rx_word_i,
  input  logic              tx_char_i,
  output logic [DATA_W-1:0] data_o,
  output logic [2:0]        ctl_o,
  output logic              word_par_o,
  output logic              char_par_o,
  output logic              word_err_o,
  output logic              char_err_o,
  output logic [LINE_W-1:0] tx_word_o
);
  import dual_parity_pkg::*;

  localparam int WORD_IN_W = DATA_W + 2;
  localparam int CHAR_IN_W = CHAR_W + 1;
  localparam int CHK_IN_W  = CHAR_W + 2;

  logic [DATA_W-1:0]    data_q;
  logic [2:0]           ctl_q;
  logic [WORD_IN_W-1:0] word_tree_in;
  logic [CHAR_IN_W-1:0] char_tree_in;
  logic [CHK_IN_W-1:0]  chk_tree_in;
  logic                 word_par_w;
  logic                 char_par_w;
  logic                 char_chk_w;
  tx_fmt_e              fmt;

  rx_capture #(.DATA_W(DATA_W), .CTL_W(3)) u_cap (
    .clk    (clk),
    .rst    (rst),
    .load_i (load_i),
    .rx_i   (rx_word_i),
    .data_q (data_q),
    .ctl_q  (ctl_q)
  );

  assign word_tree_in = {ctl_q[1:0], data_q};
  assign char_tree_in = {ctl_q[0], data_q[CHAR_W-1:0]};
  assign chk_tree_in  = {ctl_q[2], ctl_q[0], data_q[CHAR_W-1:0]};

  parity_tree #(.WIDTH(WORD_IN_W), .ODD(ODD_PAR)) u_word_tree (
    .bits_i (word_tree_in),
    .par_o  (word_par_w)
  );

  parity_tree #(.WIDTH(CHAR_IN_W), .ODD(ODD_PAR)) u_char_tree (
    .bits_i (char_tree_in),
    .par_o  (char_par_w)
  );

  // Folding the stored parity bit into the character set gives a syndrome:
  // its completing bit is 1 exactly when the eight-level character is wrong.
  parity_tree #(.WIDTH(CHK_IN_W), .ODD(ODD_PAR)) u_chk_tree (
    .bits_i (chk_tree_in),
    .par_o  (char_chk_w)
  );

  assign fmt = tx_char_i ? FMT_CHAR : FMT_WORD;

  tx_formatter #(.DATA_W(DATA_W), .CHAR_W(CHAR_W)) u_fmt (
    .fmt_i      (fmt),
    .data_i     (data_q),
    .ctl_i      (ctl_q),
    .word_par_i (word_par_w),
    .char_par_i (char_par_w),
    .tx_o       (tx_word_o)
  );

  assign data_o     = data_q;
  assign ctl_o      = ctl_q;
  assign word_par_o = word_par_w;
  assign char_par_o = char_par_w;
  assign word_err_o = word_par_w ^ ctl_q[2];
  assign char_err_o = char_chk_w;
endmodule

// File: rtl/dual_parity_net_chk.sv
module dual_parity_net_chk #(
  parameter int DATA_W  = 18,
  parameter int CHAR_W  = 6,
  parameter bit ODD_PAR = 1'b1,
  localparam int LINE_W = DATA_W + 3
) (
  input logic              clk,
  input logic              rst,
  input logic              load_i,
  input logic [LINE_W-1:0] rx_word_i,
  input logic              tx_char_i,
  input logic [DATA_W-1:0] data_o,
  input logic [2:0]        ctl_o,
  input logic              word_par_o,
  input logic              char_par_o,
  input logic              word_err_o,
  input logic              char_err_o,
  input logic [LINE_W-1:0] tx_word_o
);
  localparam int ZERO_W = LINE_W - 2 - CHAR_W;

  // R1
  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (data_o == '0 && ctl_o == '0));

  // R2
  a_r2_load_split: assert property (@(posedge clk) disable iff (rst)
    load_i |=> (data_o == $past(rx_word_i[DATA_W-1:0]) &&
                ctl_o  == $past(rx_word_i[LINE_W-1:DATA_W])));

  // R3
  a_r3_hold: assert property (@(posedge clk) disable iff (rst)
    !load_i |=> ($stable(data_o) && $stable(ctl_o)));

  // R4
  a_r4_word_sense: assert property (@(posedge clk) disable iff (rst)
    ((($countones({data_o, ctl_o[1:0], word_par_o}) % 2) == 1) == ODD_PAR));

  // R5
  a_r5_char_sense: assert property (@(posedge clk) disable iff (rst)
    ((($countones({data_o[CHAR_W-1:0], ctl_o[0], char_par_o}) % 2) == 1) == ODD_PAR));

  // R6
  a_r6_word_flag: assert property (@(posedge clk) disable iff (rst)
    word_err_o == (word_par_o != ctl_o[2]));

  // R7
  a_r7_char_flag: assert property (@(posedge clk) disable iff (rst)
    char_err_o == (char_par_o != ctl_o[2]));

  // R9
  a_r9_word_fmt: assert property (@(posedge clk) disable iff (rst)
    !tx_char_i |-> (tx_word_o == {word_par_o, ctl_o[1:0], data_o}));

  // R10
  a_r10_char_fmt: assert property (@(posedge clk) disable iff (rst)
    tx_char_i |-> (tx_word_o[LINE_W-2:CHAR_W+1] == {ZERO_W{1'b0}} &&
                   tx_word_o[LINE_W-1] == char_par_o &&
                   tx_word_o[CHAR_W] == ctl_o[0] &&
                   tx_word_o[CHAR_W-1:0] == data_o[CHAR_W-1:0]));
endmodule

bind dual_parity_net dual_parity_net_chk #(
  .DATA_W(DATA_W), .CHAR_W(CHAR_W), .ODD_PAR(ODD_PAR)
) u_chk (
  .clk(clk), .rst(rst), .load_i(load_i), .rx_word_i(rx_word_i),
  .tx_char_i(tx_char_i), .data_o(data_o), .ctl_o(ctl_o),
  .word_par_o(word_par_o), .char_par_o(char_par_o),
  .word_err_o(word_err_o), .char_err_o(char_err_o), .tx_word_o(tx_word_o)
);

// File: tb/dual_parity_net_tb.sv
module dual_parity_net_tb;
  logic        clk = 1'b0;
  logic        rst;
  logic        load_i;
  logic [20:0] rx_word_i;
  logic        tx_char_i;
  logic [17:0] data_o, data_e;
  logic [2:0]  ctl_o, ctl_e;
  logic        wpar, cpar, werr, cerr;
  logic        wpar_e, cpar_e, werr_e, cerr_e;
  logic [20:0] tx_o, tx_e;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;
  logic ld_d = 1'b0;

  typedef struct packed {
    logic [20:0] rx;
    logic        mode;
  } item_t;
  item_t sb_q[$];

  always #10 clk = ~clk;

  dual_parity_net u_dut (
    .clk(clk), .rst(rst), .load_i(load_i), .rx_word_i(rx_word_i),
    .tx_char_i(tx_char_i), .data_o(data_o), .ctl_o(ctl_o),
    .word_par_o(wpar), .char_par_o(cpar), .word_err_o(werr),
    .char_err_o(cerr), .tx_word_o(tx_o)
  );

  dual_parity_net #(.ODD_PAR(1'b0)) u_dut_even (
    .clk(clk), .rst(rst), .load_i(load_i), .rx_word_i(rx_word_i),
    .tx_char_i(tx_char_i), .data_o(data_e), .ctl_o(ctl_e),
    .word_par_o(wpar_e), .char_par_o(cpar_e), .word_err_o(werr_e),
    .char_err_o(cerr_e), .tx_word_o(tx_e)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Reference model: count ones among the lines each generator covers.
  function automatic logic ones_odd(input logic [20:0] v, input logic [20:0] mask);
    int n = 0;
    for (int i = 0; i < 21; i++) if (mask[i] && v[i]) n++;
    return (n % 2) == 1;
  endfunction

  localparam logic [20:0] WMASK = 21'h0FFFFF;              // lines 1..20
  localparam logic [20:0] CMASK = 21'h04003F;              // lines 1..6 and 19

  always @(posedge clk) ld_d <= load_i & ~rst;

  // Monitor: pops one expected item per completed load and compares.
  always @(negedge clk) begin
    if (ld_d && sb_q.size() > 0) begin
      item_t it;
      logic wo, co, we, ce;
      logic [20:0] txo, txe;
      it = sb_q.pop_front();
      wo = ~ones_odd(it.rx, WMASK);
      co = ~ones_odd(it.rx, CMASK);
      we = ~wo;
      ce = ~co;
      check("R2 data", 32'(data_o), 32'(it.rx[17:0]));
      check("R2 ctl", 32'(ctl_o), 32'(it.rx[20:18]));
      check("R4 R8 word parity odd", 32'(wpar), 32'(wo));
      check("R5 R8 char parity odd", 32'(cpar), 32'(co));
      check("R4 word parity even", 32'(wpar_e), 32'(we));
      check("R5 char parity even", 32'(cpar_e), 32'(ce));
      check("R6 word flag", 32'(werr), 32'(wo != it.rx[20]));
      check("R7 char flag", 32'(cerr), 32'(co != it.rx[20]));
      check("R6 word flag even", 32'(werr_e), 32'(we != it.rx[20]));
      check("R7 char flag even", 32'(cerr_e), 32'(ce != it.rx[20]));
      if (it.mode) begin
        txo = {co, 13'b0, it.rx[18], it.rx[5:0]};
        txe = {ce, 13'b0, it.rx[18], it.rx[5:0]};
        check("R10 char format", 32'(tx_o), 32'(txo));
        check("R10 char format even", 32'(tx_e), 32'(txe));
      end else begin
        txo = {wo, it.rx[19:0]};
        txe = {we, it.rx[19:0]};
        check("R9 word format", 32'(tx_o), 32'(txo));
        check("R9 word format even", 32'(tx_e), 32'(txe));
      end
    end
  end

  // Driver: load one word, then one idle cycle so the monitor sees it.
  task automatic send(input logic [20:0] w, input logic mode);
    item_t it;
    @(negedge clk);
    rx_word_i = w;
    tx_char_i = mode;
    load_i    = 1'b1;
    it.rx = w; it.mode = mode;
    sb_q.push_back(it);
    @(negedge clk);
    load_i = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    rst = 1'b1; load_i = 1'b0; rx_word_i = '0; tx_char_i = 1'b0;
    @(negedge clk);
    // R1: reset taking priority over a simultaneous load
    load_i = 1'b1; rx_word_i = 21'h1FFFFF;
    @(negedge clk);
    load_i = 1'b0;
    check("R1 data", 32'(data_o), 32'h0);
    check("R1 ctl", 32'(ctl_o), 32'h0);
    check("R1 word parity of zero", 32'(wpar), 32'h1);
    check("R1 char flag of zero", 32'(cerr), 32'h1);
    rst = 1'b0;
    @(negedge clk);

    send(21'h000000, 1'b0);
    send(21'h1FFFFF, 1'b0);
    send(21'h1FFFFF, 1'b1);
    send(21'h040000, 1'b0);   // line 19 only
    send(21'h080000, 1'b1);   // line 20 only
    send(21'h100000, 1'b0);   // line 21 only
    send(21'h10002A, 1'b1);
    send(21'h12AB55, 1'b0);
    send(21'h0C0F0F, 1'b1);
    for (int k = 0; k < 24; k++)
      send(21'((k * 21'h0A3B5) ^ (k << 15)), k[0]);

    // R3: new lines without a load leave the stored word untouched
    send(21'h15A5A5, 1'b0);
    @(negedge clk);
    rx_word_i = 21'h0A5A5A;
    @(negedge clk);
    @(negedge clk);
    check("R3 data held", 32'(data_o), 32'h1A5A5);
    check("R3 ctl held", 32'(ctl_o), 32'h5);

    // R1: reset after activity
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    check("R1 data after reset", 32'(data_o), 32'h0);
    check("R1 ctl after reset", 32'(ctl_o), 32'h0);

    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule